// File: doc/BRIEF.md
# Conditional Bidirectional DSP Shift Unit

This unit is the shift and copy slice of a DSP datapath. It receives the low 16 bits of a parallel DSP instruction, the two source operand values already read from the register file (called Sx and Sy here), and the current DSP condition flag. It then produces one result beat: a destination write enable, a 4-bit destination index and the result value. Three operation families are decoded: a logical shift, an arithmetic shift and a register copy from either source. For the shifts, the sign of a small two's-complement field in Sy chooses the direction. Every operation carries a 2-bit condition code. The code makes the operation unconditional, or makes it depend on the flag being set or clear.

The input side is a valid/ready stream: one instruction is taken on each clock edge where `in_valid` and `in_ready` are both high. The output side is a one-entry registered valid/ready stream. A result appears one clock after its instruction is accepted and stays unchanged until the consumer takes it with `out_ready`. A held result blocks new input, and the output register can be refilled on the same edge that empties it, so the unit sustains one instruction per clock. Every accepted instruction gives exactly one output beat, including no-ops and rejected words. Only `out_we` tells the consumer whether to write.

Top module: `dsu_top`

## Requirements
- R1: The instruction word is split as follows. Bits [15:8] are the opcode, [7:6] the Sx select, [5:4] the Sy select and [3:0] the destination index. Opcode bits [7:2] = 100000 is a logical shift, 100100 an arithmetic shift, 110110 a copy of Sx and 111110 a copy of Sy. Any other opcode gives a beat with `out_illegal`=1 and `out_we`=0.
- R2: Opcode bits [1:0] are the condition. 01 always executes. 10 executes only when `in_dc`=1. 11 executes only when `in_dc`=0. A failed condition gives a beat with `out_we`=0 and `out_illegal`=0.
- R3: Condition code 00 is reserved and gives a beat with `out_illegal`=1 and `out_we`=0.
- R4: The shift count is the low $clog2(WIDTH)+1 bits of Sy, read as two's complement; the higher bits of Sy are ignored. A count of zero or more shifts Sx left by the count. A negative count shifts Sx right by the count's magnitude.
- R5: A logical right shift fills with zeros. A left shift of either kind fills with zeros from the bottom.
- R6: An arithmetic right shift fills with copies of Sx's top bit.
- R7: A magnitude of WIDTH or more gives a full shift: all zeros, or all copies of the sign bit for an arithmetic right shift.
- R8: A copy sends the chosen operand unchanged to the result. A copy of Sx needs the Sy select to be 00, and a copy of Sy needs the Sx select to be 00; otherwise the word is illegal.
- R9: The result beat (`out_valid`, `out_we`, `out_dz`, `out_data`, `out_illegal`) appears one clock after acceptance. Back-to-back instructions are accepted and delivered one per clock.
- R10: `in_ready` is high when the output register is empty or is being taken in that cycle. While `out_valid`=1 and `out_ready`=0, all output fields hold their values.
- R11: After reset, `out_valid`, `out_we` and `out_illegal` are 0, `out_dz` and `out_data` are 0, and `in_ready` is 1.
- R12: Whenever `out_we`=0, `out_dz` and `out_data` are 0. `out_we` is never 1 without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction beat offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_insn | input | 16 | Low word of the parallel DSP instruction |
| in_sx | input | WIDTH | Value of source Sx |
| in_sy | input | WIDTH | Value of source Sy (also the shift count) |
| in_dc | input | 1 | DSP condition flag |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_we | output | 1 | Destination is to be written |
| out_dz | output | 4 | Destination register index |
| out_data | output | WIDTH | Result value |
| out_illegal | output | 1 | Instruction word was rejected |

## Verification
The properties assume that `in_insn`, `in_sx`, `in_sy` and `in_dc` are meaningful only in cycles where `in_valid` is high, and that the consumer may hold `out_ready` low for any number of cycles. The condition property samples the condition code and the flag on the accepting edge, so it needs those inputs to be stable around that edge. The stimulus changes every input only on the falling clock edge and drops `in_valid` once each beat is taken. It also covers stalls by holding `out_ready` low while a second instruction waits.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

  typedef enum logic [1:0] {
    OP_LSHIFT = 2'd0,
    OP_ASHIFT = 2'd1,
    OP_COPYX  = 2'd2,
    OP_COPYY  = 2'd3
  } dsu_op_e;

  typedef enum logic [1:0] {
    CC_RSVD   = 2'b00,
    CC_ALWAYS = 2'b01,
    CC_IFSET  = 2'b10,
    CC_IFCLR  = 2'b11
  } dsu_cc_e;

  typedef struct packed {
    logic    legal;
    dsu_op_e op;
    dsu_cc_e cc;
    logic [3:0] dz;
  } dsu_dec_t;

  localparam logic [5:0] OPC_LSHIFT = 6'b100000;
  localparam logic [5:0] OPC_ASHIFT = 6'b100100;
  localparam logic [5:0] OPC_COPYX  = 6'b110110;
  localparam logic [5:0] OPC_COPYY  = 6'b111110;

endpackage

// File: rtl/dsu_decode.sv
module dsu_decode
  import dsu_pkg::*;
(
  input  logic [15:0] insn,
  output dsu_dec_t    dec
);

  logic [7:0] opc;
  logic [1:0] xsel;
  logic [1:0] ysel;
  logic       op_ok;
  dsu_op_e    op;

  assign opc  = insn[15:8];
  assign xsel = insn[7:6];
  assign ysel = insn[5:4];

  always_comb begin
    op_ok = 1'b0;
    op    = OP_LSHIFT;
    unique case (opc[7:2])
      OPC_LSHIFT: begin op = OP_LSHIFT; op_ok = 1'b1; end
      OPC_ASHIFT: begin op = OP_ASHIFT; op_ok = 1'b1; end
      OPC_COPYX:  begin op = OP_COPYX;  op_ok = (ysel == 2'b00); end
      OPC_COPYY:  begin op = OP_COPYY;  op_ok = (xsel == 2'b00); end
      default:    begin op = OP_LSHIFT; op_ok = 1'b0; end
    endcase
  end

  always_comb begin
    dec.op    = op;
    dec.cc    = dsu_cc_e'(opc[1:0]);
    dec.legal = op_ok && (opc[1:0] != 2'b00);
    dec.dz    = insn[3:0];
  end

endmodule

// File: rtl/dsu_cond.sv
module dsu_cond
  import dsu_pkg::*;
(
  input  dsu_cc_e cc,
  input  logic    dc,
  output logic    pass
);

  always_comb begin
    unique case (cc)
      CC_ALWAYS: pass = 1'b1;
      CC_IFSET:  pass = dc;
      CC_IFCLR:  pass = !dc;
      default:   pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsu_shifter.sv
module dsu_shifter #(
  parameter int WIDTH = 32,
  localparam int LG  = $clog2(WIDTH),
  localparam int SHW = LG + 1
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [SHW-1:0]   amount,
  input  logic             arith,
  output logic [WIDTH-1:0] result
);

  localparam logic [SHW-1:0] WLIM = SHW'(WIDTH);

  logic             neg;
  logic [SHW-1:0]   mag;
  logic             sat;
  logic             fill;
  logic [WIDTH-1:0] lstg [0:LG];
  logic [WIDTH-1:0] rstg [0:LG];

  assign neg  = amount[SHW-1];
  assign mag  = neg ? (~amount + SHW'(1)) : amount;
  assign sat  = (mag >= WLIM);
  assign fill = arith & operand[WIDTH-1];

  assign lstg[0] = operand;
  assign rstg[0] = operand;

  for (genvar g = 0; g < LG; g++) begin : g_stage
    localparam int SH = 1 << g;
    assign lstg[g+1] = mag[g] ? {lstg[g][WIDTH-1-SH:0], {SH{1'b0}}} : lstg[g];
    assign rstg[g+1] = mag[g] ? {{SH{fill}}, rstg[g][WIDTH-1:SH]} : rstg[g];
  end

  always_comb begin
    if (!neg) begin
      result = sat ? '0 : lstg[LG];
    end else begin
      result = sat ? {WIDTH{fill}} : rstg[LG];
    end
  end

endmodule

// File: rtl/dsu_top.sv
module dsu_top
  import dsu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_insn,
  input  logic [WIDTH-1:0] in_sx,
  input  logic [WIDTH-1:0] in_sy,
  input  logic             in_dc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_we,
  output logic [3:0]       out_dz,
  output logic [WIDTH-1:0] out_data,
  output logic             out_illegal
);

  dsu_dec_t         dec;
  logic             cond_ok;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] res;
  logic             nxt_we;
  logic             fire;

  dsu_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  dsu_cond u_cond (
    .cc   (dec.cc),
    .dc   (in_dc),
    .pass (cond_ok)
  );

  dsu_shifter #(.WIDTH(WIDTH)) u_shf (
    .operand (in_sx),
    .amount  (in_sy[SHW-1:0]),
    .arith   (dec.op == OP_ASHIFT),
    .result  (shifted)
  );

  always_comb begin
    unique case (dec.op)
      OP_COPYX: res = in_sx;
      OP_COPYY: res = in_sy;
      default:  res = shifted;
    endcase
  end

  assign nxt_we   = dec.legal && cond_ok;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_we      <= 1'b0;
      out_dz      <= '0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (fire) begin
      out_valid   <= 1'b1;
      out_we      <= nxt_we;
      out_dz      <= nxt_we ? dec.dz : 4'd0;
      out_data    <= nxt_we ? res : '0;
      out_illegal <= !dec.legal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_we      <= 1'b0;
      out_dz      <= '0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end
  end

endmodule

// File: rtl/dsu_checker.sv
module dsu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_cc,
  input logic             in_dc,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_we,
  input logic [3:0]       out_dz,
  input logic [WIDTH-1:0] out_data,
  input logic             out_illegal
);

  a_r9_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_valid && out_ready) |=> !out_valid);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dz)
                                   && $stable(out_we) && $stable(out_illegal)));

  a_r10_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r2_ifset_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cc == 2'b10 && !in_dc) |=> !out_we);

  a_r2_ifclr_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cc == 2'b11 && in_dc) |=> !out_we);

  a_r3_reserved_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cc == 2'b00) |=> (out_illegal && !out_we));

  a_r1_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && !out_we));

  a_r12_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);

  a_r12_quiet_when_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |-> (out_data == '0 && out_dz == 4'd0));

endmodule

bind dsu_top dsu_checker #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_cc       (in_insn[9:8]),
  .in_dc       (in_dc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_we      (out_we),
  .out_dz      (out_dz),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/dsu_top_tb_top.sv
module dsu_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_insn = '0;
  logic [W-1:0]  in_sx = '0;
  logic [W-1:0]  in_sy = '0;
  logic          in_dc = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_we;
  logic [3:0]    out_dz;
  logic [W-1:0]  out_data;
  logic          out_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsu_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_sx(in_sx), .in_sy(in_sy), .in_dc(in_dc),
    .out_valid(out_valid), .out_ready(out_ready), .out_we(out_we),
    .out_dz(out_dz), .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] insn, input logic [W-1:0] sx,
                       input logic [W-1:0] sy, input logic dc);
    in_valid = 1'b1; in_insn = insn; in_sx = sx; in_sy = sy; in_dc = dc;
  endtask

  // packs {valid, we, illegal, dz, data}
  task automatic expect_beat(input string tag, input logic we, input logic [3:0] dz,
                             input logic [W-1:0] data, input logic ill);
    check(tag, {25'd0, out_valid, out_we, out_illegal, out_dz, out_data},
               {25'd0, 1'b1, we, ill, dz, data});
  endtask

  task automatic one(input string tag, input logic [15:0] insn, input logic [W-1:0] sx,
                     input logic [W-1:0] sy, input logic dc, input logic we,
                     input logic [3:0] dz, input logic [W-1:0] data, input logic ill);
    drive(insn, sx, sy, dc);
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat(tag, we, dz, data, ill);
  endtask

  task automatic t_reset();
    check("R11 reset outputs", {58'd0, out_valid, out_we, out_illegal, in_ready, |out_dz, |out_data},
                               {58'd0, 6'b000100});
  endtask

  task automatic t_basic_shifts();
    one("R4 R5 logical left",  16'h8115, 32'h0000_00F1, 32'd4,        1'b0, 1, 4'h5, 32'h0000_0F10, 0);
    one("R5 logical right",    16'h8115, 32'h8000_00F0, 32'hFFFF_FFFC, 1'b0, 1, 4'h5, 32'h0800_000F, 0);
    one("R6 arith right",      16'h9115, 32'h8000_00F0, 32'hFFFF_FFFC, 1'b0, 1, 4'h5, 32'hF800_000F, 0);
    one("R5 arith left",       16'h9119, 32'hC000_0001, 32'd1,        1'b0, 1, 4'h9, 32'h8000_0002, 0);
    one("R4 upper sy ignored", 16'h8102, 32'h0000_0001, 32'h0000_0043, 1'b0, 1, 4'h2, 32'h0000_0008, 0);
    one("R4 zero count",       16'h9103, 32'h8765_4321, 32'h0000_0040, 1'b0, 1, 4'h3, 32'h8765_4321, 0);
  endtask

  task automatic t_saturate();
    one("R7 logical full right", 16'h8101, 32'h8000_0000, 32'hFFFF_FFE0, 1'b0, 1, 4'h1, 32'h0, 0);
    one("R7 arith full neg",     16'h9101, 32'h8000_0000, 32'hFFFF_FFE0, 1'b0, 1, 4'h1, 32'hFFFF_FFFF, 0);
    one("R7 arith full pos",     16'h9101, 32'h7FFF_FFFF, 32'hFFFF_FFE0, 1'b0, 1, 4'h1, 32'h0, 0);
  endtask

  task automatic t_sweep();
    logic [W-1:0] sx;
    sx = 32'hA5A5_0001;
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] sy;
      sy = W'(k);
      one("R4 sweep left", 16'h8104, sx, sy, 1'b0, 1, 4'h4, sx << k, 0);
    end
    for (int k = 1; k <= W; k++) begin
      logic [W-1:0] sy;
      sy = W'(-k);
      one("R5 sweep logical right", 16'h8104, sx, sy, 1'b0, 1, 4'h4, sx >> k, 0);
      one("R6 sweep arith right",   16'h9104, sx, sy, 1'b0, 1, 4'h4, W'($signed(sx) >>> k), 0);
    end
  endtask

  task automatic t_cond();
    one("R2 ifset dc0 nop",  16'h8216, 32'h1, 32'd3, 1'b0, 0, 4'h0, 32'h0, 0);
    one("R2 ifset dc1 runs", 16'h8216, 32'h1, 32'd3, 1'b1, 1, 4'h6, 32'h8, 0);
    one("R2 ifclr dc1 nop",  16'h8316, 32'h1, 32'd3, 1'b1, 0, 4'h0, 32'h0, 0);
    one("R2 ifclr dc0 runs", 16'h9316, 32'h1, 32'd3, 1'b0, 1, 4'h6, 32'h8, 0);
    one("R2 always dc1",     16'h8116, 32'h1, 32'd3, 1'b1, 1, 4'h6, 32'h8, 0);
    one("R2 copy ifset dc0", 16'hDA47, 32'h55, 32'h0, 1'b0, 0, 4'h0, 32'h0, 0);
  endtask

  task automatic t_illegal();
    one("R3 reserved cc shift", 16'h8016, 32'h1, 32'd3, 1'b0, 0, 4'h0, 32'h0, 1);
    one("R3 reserved cc copy",  16'hD847, 32'h1, 32'd0, 1'b1, 0, 4'h0, 32'h0, 1);
    one("R1 bad bits 3:2",      16'h8516, 32'h1, 32'd3, 1'b0, 0, 4'h0, 32'h0, 1);
    one("R1 unknown opcode",    16'hA116, 32'h1, 32'd3, 1'b0, 0, 4'h0, 32'h0, 1);
  endtask

  task automatic t_copy();
    one("R8 copy sx",        16'hD947, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0, 1, 4'h7, 32'h1234_5678, 0);
    one("R8 copy sx bad yy", 16'hD957, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0, 0, 4'h0, 32'h0, 1);
    one("R8 copy sy",        16'hF923, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0, 1, 4'h3, 32'hDEAD_BEEF, 0);
    one("R8 copy sy bad xx", 16'hF963, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0, 0, 4'h0, 32'h0, 1);
    one("R8 copy sy ifclr",  16'hFB2A, 32'h0, 32'hCAFE_0001, 1'b0, 1, 4'hA, 32'hCAFE_0001, 0);
  endtask

  task automatic t_throughput();
    drive(16'h8111, 32'h3, 32'd1, 1'b0);
    @(negedge clk);
    expect_beat("R9 back-to-back first", 1, 4'h1, 32'h6, 0);
    check("R9 ready while draining", {63'd0, in_ready}, 64'd1);
    drive(16'hF912, 32'h0, 32'h77, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat("R9 back-to-back second", 1, 4'h2, 32'h77, 0);
    @(negedge clk);
    check("R9 empties after take", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    drive(16'h8118, 32'h1, 32'd2, 1'b0);
    @(negedge clk);
    expect_beat("R10 stalled beat", 1, 4'h8, 32'h4, 0);
    drive(16'hD94C, 32'h99, 32'h0, 1'b0);
    check("R10 ready low on stall", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    expect_beat("R10 held during stall", 1, 4'h8, 32'h4, 0);
    check("R10 ready still low", {63'd0, in_ready}, 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat("R10 waiting beat delivered", 1, 4'hC, 32'h99, 0);
    @(negedge clk);
    check("R10 empty after release", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_shifts();
    t_saturate();
    t_sweep();
    t_cond();
    t_illegal();
    t_copy();
    t_throughput();
    t_backpressure();
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule